// File: doc/BRIEF.md
# Repeat and Normalize Sequencer

This block is a small hardware loop controller that sits beside an accumulator pair A:X. It keeps a signed shift counter that is half as wide as A. Two arming operations, repeat and normalise, make the next instruction the fetch stage issues run over and over. Each pass decrements the counter. The loop ends when the counter reaches zero. In normalise mode it also ends as soon as the sign bit of A differs from the bit just below it. Two more operations move the counter into and out of the low half of A.

For this block the only instruction that can be repeated is a one-place long arithmetic left shift of A:X. The fetch stage hands over operations through a valid/ready handshake. While a loop runs, the sequencer holds the fetch stage off. It pulses done when the loop exits. A separate port loads A and X directly.

Bit conventions: the sign bit of A is `a_out[W-1]` and the bit below it is `a_out[W-2]`. The low half of A is `a_out[W/2-1:0]`. The counter is `W/2` bits wide.

Top module: `repeat_norm_seq`

## Requirements
- R1: After reset, A, X, the counter, overflow, busy and done are all 0, no operation is armed, and op_ready is 1.
- R2: With the block idle, ld_valid copies ld_a into A and ld_x into X and clears overflow. While ld_valid is high, op_ready is 0. While busy, ld_valid is ignored.
- R3: Op code 3 (counter from A) copies the low half of A into the counter. A is left unchanged.
- R4: Op code 4 (counter to A) copies the counter into the low half of A. The high half of A is left unchanged.
- R5: Op code 5 with nothing armed shifts A:X left by one place in one cycle. The MSB of X enters the LSB of A, the MSB of A is lost, and 0 enters the LSB of X. Overflow becomes 1, and stays 1 until the next load, if the sign bit of A changes.
- R6: Op code 1 (repeat) arms a loop. If the next accepted operation is code 5, the shift runs repeatedly. Before each pass the counter is tested for zero; each pass then decrements it by one, modulo 2^(W/2). A negative start value -k therefore gives 2^(W/2)-k passes. Overflow follows R5 on every pass.
- R7: Op code 2 (normalise) arms a loop. If the next accepted operation is code 5, the shift repeats until A's sign bit differs from the bit below it, or until the counter is zero. Both conditions are tested before each pass.
- R8: If the stop condition already holds when the armed shift is accepted, the shift runs zero times. A, X, the counter and overflow are left unchanged, and the sequencer returns to accepting operations.
- R9: A loop of n passes holds busy high, and op_ready low, for n+1 cycles starting in the cycle after acceptance. Done is high for exactly the one cycle after busy falls. Done stays low for all non-looping operations.
- R10: An arm applies only to the next accepted operation. Any operation other than code 5 clears the arm and runs once as usual. A new code 1 or code 2 replaces a pending arm.
- R11: Op code 0 and the unused codes 6 and 7 change nothing except clearing any pending arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Load A and X from ld_a and ld_x |
| ld_a | input | W | Value loaded into A |
| ld_x | input | W | Value loaded into X |
| op_valid | input | 1 | Operation offered by the fetch stage |
| op_code | input | 3 | Operation code (0 none, 1 repeat, 2 normalise, 3 counter from A, 4 counter to A, 5 long left shift) |
| op_ready | output | 1 | Operation accepted this cycle when high together with op_valid |
| busy | output | 1 | A repeat loop is running |
| done | output | 1 | One-cycle pulse after a loop exits |
| a_out | output | W | Accumulator A |
| x_out | output | W | Extension register X |
| cnt_out | output | W/2 | Shift counter |
| ovf | output | 1 | Sticky overflow |

## Verification
The bench builds the block with W = 12, which makes the counter 6 bits wide. At that size, a negative start count such as -2 wraps to 62 passes, so the wrap case runs well within the run length. Every sign and next-bit pattern of a 12-bit A can be reached, both by directed values and by random loads. At this width, a normalise loop can be stopped either by the counter or by the bit test, and the bench reaches both outcomes. It also reaches the case where the stop condition already holds when the loop starts.

// File: rtl/rns_pkg.sv
package rns_pkg;

    localparam logic [2:0] OP_NONE   = 3'd0;
    localparam logic [2:0] OP_RPT    = 3'd1;
    localparam logic [2:0] OP_NRM    = 3'd2;
    localparam logic [2:0] OP_CNT_LD = 3'd3;
    localparam logic [2:0] OP_CNT_ST = 3'd4;
    localparam logic [2:0] OP_SHL    = 3'd5;

    typedef enum logic [1:0] {
        ARM_NONE = 2'd0,
        ARM_RPT  = 2'd1,
        ARM_NRM  = 2'd2
    } arm_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } st_e;

endpackage

// File: rtl/rns_stop_eval.sv
module rns_stop_eval #(
    parameter int CW = 6
) (
    input  logic [CW-1:0] cnt,
    input  logic          nrm_mode,
    input  logic          a_sign,
    input  logic          a_next,
    output logic          stop
);
    logic cnt_zero;
    logic normalised;

    always_comb begin
        cnt_zero   = (cnt == '0);
        normalised = a_sign ^ a_next;
        stop       = cnt_zero | (nrm_mode & normalised);
    end
endmodule

// File: rtl/rns_shifter.sv
module rns_shifter #(
    parameter int W = 12
) (
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] x_in,
    output logic [W-1:0] a_sh,
    output logic [W-1:0] x_sh,
    output logic         sign_flip
);
    always_comb begin
        a_sh      = {a_in[W-2:0], x_in[W-1]};
        x_sh      = {x_in[W-2:0], 1'b0};
        sign_flip = a_in[W-1] ^ a_in[W-2];
    end
endmodule

// File: rtl/repeat_norm_seq.sv
module repeat_norm_seq
    import rns_pkg::*;
#(
    parameter int W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld_valid,
    input  logic [W-1:0]    ld_a,
    input  logic [W-1:0]    ld_x,
    input  logic            op_valid,
    input  logic [2:0]      op_code,
    output logic            op_ready,
    output logic            busy,
    output logic            done,
    output logic [W-1:0]    a_out,
    output logic [W-1:0]    x_out,
    output logic [W/2-1:0]  cnt_out,
    output logic            ovf
);
    localparam int CW = W / 2;

    typedef struct packed {
        st_e           st;
        arm_e          arm;
        arm_e          mode;
        logic [W-1:0]  a;
        logic [W-1:0]  x;
        logic [CW-1:0] cnt;
        logic          ovf;
        logic          done;
    } seq_t;

    seq_t q, d;

    logic [W-1:0] sh_a, sh_x;
    logic         sh_flip;
    logic         stop;
    logic         run_nrm;
    logic         op_fire;

    assign run_nrm = (q.mode == ARM_NRM);

    rns_shifter #(.W(W)) u_shift (
        .a_in      (q.a),
        .x_in      (q.x),
        .a_sh      (sh_a),
        .x_sh      (sh_x),
        .sign_flip (sh_flip)
    );

    rns_stop_eval #(.CW(CW)) u_stop (
        .cnt      (q.cnt),
        .nrm_mode (run_nrm),
        .a_sign   (q.a[W-1]),
        .a_next   (q.a[W-2]),
        .stop     (stop)
    );

    always_comb begin
        op_ready = (q.st == ST_IDLE) && !ld_valid;
        op_fire  = op_valid && op_ready;

        d      = q;
        d.done = 1'b0;

        if (q.st == ST_RUN) begin
            if (stop) begin
                d.st   = ST_IDLE;
                d.done = 1'b1;
            end else begin
                d.a   = sh_a;
                d.x   = sh_x;
                d.ovf = q.ovf | sh_flip;
                d.cnt = q.cnt - 1'b1;
            end
        end else if (ld_valid) begin
            d.a   = ld_a;
            d.x   = ld_x;
            d.ovf = 1'b0;
        end else if (op_fire) begin
            d.arm = ARM_NONE;
            case (op_code)
                OP_RPT:    d.arm = ARM_RPT;
                OP_NRM:    d.arm = ARM_NRM;
                OP_CNT_LD: d.cnt = q.a[CW-1:0];
                OP_CNT_ST: d.a[CW-1:0] = q.cnt;
                OP_SHL: begin
                    if (q.arm != ARM_NONE) begin
                        d.st   = ST_RUN;
                        d.mode = q.arm;
                    end else begin
                        d.a   = sh_a;
                        d.x   = sh_x;
                        d.ovf = q.ovf | sh_flip;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= ST_IDLE;
            q.arm  <= ARM_NONE;
            q.mode <= ARM_NONE;
            q.a    <= '0;
            q.x    <= '0;
            q.cnt  <= '0;
            q.ovf  <= 1'b0;
            q.done <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign busy    = (q.st == ST_RUN);
    assign done    = q.done;
    assign a_out   = q.a;
    assign x_out   = q.x;
    assign cnt_out = q.cnt;
    assign ovf     = q.ovf;

endmodule

// File: rtl/rns_seq_chk.sv
module rns_seq_chk #(
    parameter int W = 12
) (
    input logic           clk,
    input logic           rst_n,
    input logic           busy,
    input logic           done,
    input logic           op_valid,
    input logic           op_ready,
    input logic [2:0]     op_code,
    input logic [W-1:0]   a_out,
    input logic [W/2-1:0] cnt_out,
    input logic           nrm_mode
);
    localparam int CW = W / 2;

    // R6: during a loop the counter only holds or steps down by one
    a_r6_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |->
            (cnt_out == $past(cnt_out) || cnt_out == CW'($past(cnt_out) - 1'b1)));

    // R6: a zero counter ends the loop on the next edge
    a_r6_zero_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt_out == '0) |=> !busy);

    // R7: a normalised A ends a normalise loop on the next edge
    a_r7_norm_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && nrm_mode && (a_out[W-1] != a_out[W-2])) |=> !busy);

    // R9: done only directly after a loop ends
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R9: no operation accepted while a loop runs
    a_r9_hold_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !op_ready);

    // R4: storing the counter writes only the low half of A
    a_r4_store_half: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_ready && op_code == 3'd4) |=>
            (a_out[CW-1:0] == $past(cnt_out) && a_out[W-1:CW] == $past(a_out[W-1:CW])));
endmodule

bind repeat_norm_seq rns_seq_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .op_valid (op_valid),
    .op_ready (op_ready),
    .op_code  (op_code),
    .a_out    (a_out),
    .cnt_out  (cnt_out),
    .nrm_mode (run_nrm)
);

// File: tb/repeat_norm_seq_tb.sv
module repeat_norm_seq_tb;
    localparam int W  = 12;
    localparam int CW = W / 2;
    localparam int CLK_PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_valid = 1'b0;
    logic [W-1:0]  ld_a = '0;
    logic [W-1:0]  ld_x = '0;
    logic          op_valid = 1'b0;
    logic [2:0]    op_code = 3'd0;
    logic          op_ready, busy, done, ovf;
    logic [W-1:0]  a_out, x_out;
    logic [CW-1:0] cnt_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // bench model
    logic [W-1:0]  m_a = '0, m_x = '0;
    logic [CW-1:0] m_cnt = '0;
    logic          m_ovf = 1'b0;
    int            m_arm = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    repeat_norm_seq #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_a(ld_a), .ld_x(ld_x),
        .op_valid(op_valid), .op_code(op_code), .op_ready(op_ready), .busy(busy),
        .done(done), .a_out(a_out), .x_out(x_out), .cnt_out(cnt_out), .ovf(ovf)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cmp_state(input string tag);
        chk({tag, " A"},   32'(a_out),   32'(m_a));
        chk({tag, " X"},   32'(x_out),   32'(m_x));
        chk({tag, " cnt"}, 32'(cnt_out), 32'(m_cnt));
        chk({tag, " ovf"}, 32'(ovf),     32'(m_ovf));
    endtask

    task automatic model_shift();
        if (m_a[W-1] != m_a[W-2]) m_ovf = 1'b1;
        {m_a, m_x} = {m_a, m_x} << 1;
    endtask

    function automatic bit model_stop(input int mode);
        return (m_cnt == '0) || (mode == 2 && (m_a[W-1] != m_a[W-2]));
    endfunction

    task automatic do_load(input logic [W-1:0] a, input logic [W-1:0] x);
        @(negedge clk);
        ld_valid = 1'b1; ld_a = a; ld_x = x;
        #1;
        chk("R2 op_ready low during load", 32'(op_ready), 32'd0);
        @(negedge clk);
        ld_valid = 1'b0;
        m_a = a; m_x = x; m_ovf = 1'b0;
        cmp_state("R2 load");
    endtask

    task automatic do_op(input logic [2:0] code, input string tag);
        int reps;
        int nb;
        int mode;
        bit loop;
        @(negedge clk);
        op_valid = 1'b1; op_code = code;
        @(negedge clk);
        op_valid = 1'b0;
        loop = (code == 3'd5) && (m_arm != 0);
        mode = m_arm;
        m_arm = 0;
        case (code)
            3'd1: m_arm = 1;
            3'd2: m_arm = 2;
            3'd3: m_cnt = m_a[CW-1:0];
            3'd4: m_a[CW-1:0] = m_cnt;
            3'd5: if (!loop) model_shift();
            default: ;
        endcase
        if (loop) begin
            reps = 0;
            while (!model_stop(mode)) begin
                model_shift();
                m_cnt = m_cnt - 1'b1;
                reps++;
            end
            chk({tag, " R9 op_ready low in loop"}, 32'(op_ready), 32'd0);
            nb = 0;
            while (busy && nb < 1000) begin
                nb++;
                @(negedge clk);
            end
            chk({tag, " R9 busy cycles"}, 32'(nb), 32'(reps + 1));
            chk({tag, " R9 done pulse"}, 32'(done), 32'd1);
            @(negedge clk);
            chk({tag, " R9 done single"}, 32'(done), 32'd0);
        end else begin
            chk({tag, " R9 no busy"}, 32'(busy), 32'd0);
            chk({tag, " R9 no done"}, 32'(done), 32'd0);
        end
        cmp_state(tag);
    endtask

    task automatic set_cnt(input logic [CW-1:0] c, input logic [W-1:0] a, input logic [W-1:0] x);
        do_load({a[W-1:CW], c}, x);
        do_op(3'd3, "R3 counter from A");
        if (a[CW-1:0] != c) do_load(a, x);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_fail++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 A", 32'(a_out), 0);
        chk("R1 X", 32'(x_out), 0);
        chk("R1 cnt", 32'(cnt_out), 0);
        chk("R1 ovf", 32'(ovf), 0);
        chk("R1 busy", 32'(busy), 0);
        chk("R1 done", 32'(done), 0);
        chk("R1 op_ready", 32'(op_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 / R4
        do_load(12'h0A5, 12'h3C3);
        do_op(3'd3, "R3 counter from A");
        do_load(12'hF00, 12'h001);
        do_op(3'd4, "R4 counter to A");

        // R5 single shift with sign change
        do_load(12'h400, 12'h801);
        do_op(3'd5, "R5 single shift");
        do_op(3'd5, "R5 single shift sticky");

        // R6 repeat count 3
        set_cnt(6'd3, 12'h123, 12'h456);
        do_op(3'd1, "R6 arm");
        do_op(3'd5, "R6 repeat 3");
        // R8 repeat with zero count
        set_cnt(6'd0, 12'h5A0, 12'hFFF);
        do_op(3'd1, "R8 arm");
        do_op(3'd5, "R8 repeat zero");
        // R6 negative count wraps
        set_cnt(6'h3E, 12'h000, 12'h00F);
        do_op(3'd1, "R6 arm neg");
        do_op(3'd5, "R6 repeat negative");

        // R7 normalise until bit test
        set_cnt(6'd31, 12'h001, 12'h800);
        do_op(3'd2, "R7 arm");
        do_op(3'd5, "R7 normalise");
        // R7 counter stops first
        set_cnt(6'd2, 12'h001, 12'h000);
        do_op(3'd2, "R7 arm short");
        do_op(3'd5, "R7 normalise counter stop");
        // R8 already normalised
        set_cnt(6'd9, 12'hBC0, 12'h111);
        do_op(3'd2, "R8 arm norm");
        do_op(3'd5, "R8 normalise zero");

        // R10 disarm by other op, re-arm replaces
        set_cnt(6'd4, 12'h030, 12'h0F0);
        do_op(3'd1, "R10 arm");
        do_op(3'd4, "R10 store disarms");
        do_op(3'd5, "R10 single after disarm");
        do_op(3'd1, "R10 arm rpt");
        do_op(3'd2, "R10 rearm nrm");
        do_op(3'd5, "R10 rearmed normalise");

        // R11 unused codes
        do_op(3'd1, "R11 arm");
        do_op(3'd6, "R11 code 6");
        do_op(3'd5, "R11 single after code 6");
        do_op(3'd7, "R11 code 7");
        do_op(3'd0, "R11 code 0");

        // R2 load ignored while busy
        set_cnt(6'd5, 12'h040, 12'h000);
        do_op(3'd1, "R2 arm");
        @(negedge clk);
        op_valid = 1'b1; op_code = 3'd5;
        @(negedge clk);
        op_valid = 1'b0;
        ld_valid = 1'b1; ld_a = 12'hEEE; ld_x = 12'hDDD;
        @(negedge clk);
        ld_valid = 1'b0;
        while (busy) @(negedge clk);
        m_arm = 0;
        while (!model_stop(1)) begin
            model_shift();
            m_cnt = m_cnt - 1'b1;
        end
        cmp_state("R2 load ignored while busy");

        // random mix
        for (int i = 0; i < 400; i++) begin
            int sel;
            sel = $urandom_range(0, 9);
            if (sel < 2)
                do_load(W'($urandom), W'($urandom));
            else
                do_op(3'($urandom_range(0, 7)), "R10 random op");
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule